// File: doc/BRIEF.md
# PWM Input Period Capture

This block times an external pulse-width-modulated waveform. A select input picks one of several candidate signals. The chosen signal passes through a two-flop synchronizer and then an edge detector. A single tick counter measures the phases between edges. When a phase ends, its length is written to one of two holding registers: one for the latest low phase and one for the latest high phase. The running count is also output directly, so a reader can see how many ticks have passed since the last edge. One tick is one clock cycle, which is 10 ns at the intended clock.

Several PWM channel front ends share this single capture block, because they all listen to the same input source. A reader takes the three counts and the valid flag straight off the output registers. Changing the select discards all previous results. The flag stays low until the new source has produced both a complete low phase and a complete high phase.

Top module: `pwm_capture`

## Requirements
- R1: `srcSel` (value k, 0 to NUM_SRC-1) routes `srcIn[k]` alone into the measurement. Activity on any other `srcIn` bit has no effect on the outputs.
- R2: A level change on the selected input, first sampled at clock edge e, is acted on at edge e+2, after two synchronizer flops. The affected length register shows the new value after that edge and not before it.
- R3: On each rising edge of the synchronized input, `lowLen` takes the number of clock cycles the input was sampled low.
- R4: On each falling edge of the synchronized input, `highLen` takes the number of clock cycles the input was sampled high. `highLen` does not change on a rising edge, and `lowLen` does not change on a falling edge.
- R5: `sinceEdge` is 0 in the cycle after an edge is acted on, and rises by 1 on every later clock.
- R6: All three counts saturate at 2^CNT_W-1 and never wrap. A phase longer than that latches the all-ones value.
- R7: A change of `srcSel` clears `lowLen`, `highLen`, `sinceEdge` and `capValid` at the next clock. Edges are ignored, and `sinceEdge` is held at 0, for SYNC_STAGES+1 further cycles, so the switch itself is never measured. Counting then resumes.
- R8: `capValid` goes high only after both a low phase and a high phase have been latched since reset or the last source change. A single phase is not enough.
- R9: While `rstN` is low, all counts are 0 and `capValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock (one tick per cycle) |
| rstN | input | 1 | Active-low synchronous reset |
| srcIn | input | NUM_SRC | Candidate PWM signals, asynchronous |
| srcSel | input | SEL_W | Index of the signal to measure |
| lowLen | output | CNT_W | Length of the latest completed low phase |
| highLen | output | CNT_W | Length of the latest completed high phase |
| sinceEdge | output | CNT_W | Ticks since the last detected edge |
| capValid | output | 1 | Both phase lengths are valid for the current source |

## Verification
The bench drives every input change just after a falling clock edge. It counts rising edges from that point.

A length register is due three rising edges after its input transition: two synchronizer flops and then the latch. The bench samples it one half-cycle after that third edge. In one dedicated check it also samples after the second edge, to confirm the old value is still held.

`sinceEdge` is expected to read k-3 after k rising edges following the drive. After a select change, the clear is due after one edge, and counting is expected to restart only after SYNC_STAGES+2 edges.

// File: rtl/pwm_cap_pkg.sv
package pwm_cap_pkg;

  // Strobes from control to datapath, valid for one cycle each.
  typedef struct packed {
    logic clear;  // drop all counts (reset of measurement)
    logic rise;   // a low phase just ended
    logic fall;   // a high phase just ended
  } capStrobe_t;

endpackage

// File: rtl/pwm_cap_ctrl.sv
module pwm_cap_ctrl
  import pwm_cap_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [SEL_W-1:0]   srcSel,
  output capStrobe_t         strobe,
  output logic               capValid
);

  localparam int SETTLE  = SYNC_STAGES + 1;
  localparam int BLANK_W = $clog2(SETTLE + 1);

  logic [SEL_W-1:0]       selQ;
  logic                   selChange;
  logic [BLANK_W-1:0]     blankCnt;
  logic                   muxBit;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   synced;
  logic                   prevQ;
  logic                   lowSeen;
  logic                   highSeen;

  assign selChange = (srcSel != selQ);
  assign muxBit    = srcIn[selQ];
  assign synced    = syncQ[SYNC_STAGES-1];

  // Source register and post-switch blanking window
  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ     <= '0;
      blankCnt <= '0;
    end else if (selChange) begin
      selQ     <= srcSel;
      blankCnt <= BLANK_W'(SETTLE);
    end else if (blankCnt != '0) begin
      blankCnt <= blankCnt - 1'b1;
    end
  end

  // Synchronizer behind the select mux, then edge history
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], muxBit};
      prevQ <= synced;
    end
  end

  always_comb begin
    strobe.clear = selChange || (blankCnt != '0);
    strobe.rise  = !strobe.clear && synced && !prevQ;
    strobe.fall  = !strobe.clear && !synced && prevQ;
  end

  // Phase bookkeeping for the valid flag
  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      lowSeen  <= 1'b0;
      highSeen <= 1'b0;
    end else begin
      if (strobe.rise) lowSeen  <= 1'b1;
      if (strobe.fall) highSeen <= 1'b1;
    end
  end

  assign capValid = lowSeen && highSeen;

  p_valid_drop_r7 : assert property (@(posedge clk) disable iff (!rstN)
    selChange |=> !capValid);

  p_valid_rise_r8 : assert property (@(posedge clk) disable iff (!rstN)
    $rose(capValid) |-> $past(strobe.rise || strobe.fall));

  p_sel_track_r1 : assert property (@(posedge clk) disable iff (!rstN)
    selChange |=> (selQ == $past(srcSel)));

endmodule

// File: rtl/pwm_cap_datapath.sv
module pwm_cap_datapath
  import pwm_cap_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  capStrobe_t       strobe,
  output logic [CNT_W-1:0] lowLen,
  output logic [CNT_W-1:0] highLen,
  output logic [CNT_W-1:0] sinceEdge
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] runCnt;
  logic [CNT_W-1:0] runNext;

  // Saturating increment shared by the counter and the latches
  assign runNext = (runCnt == CNT_MAX) ? CNT_MAX : runCnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      runCnt  <= '0;
      lowLen  <= '0;
      highLen <= '0;
    end else if (strobe.rise) begin
      lowLen <= runNext;
      runCnt <= '0;
    end else if (strobe.fall) begin
      highLen <= runNext;
      runCnt  <= '0;
    end else begin
      runCnt <= runNext;
    end
  end

  assign sinceEdge = runCnt;

  p_sat_hold_r6 : assert property (@(posedge clk) disable iff (!rstN)
    (runCnt == CNT_MAX) && !strobe.clear && !strobe.rise && !strobe.fall
      |=> (runCnt == CNT_MAX));

  p_since_inc_r5 : assert property (@(posedge clk) disable iff (!rstN)
    !strobe.clear && !strobe.rise && !strobe.fall && (runCnt != CNT_MAX)
      |=> (runCnt == $past(runCnt) + 1'b1));

  p_rise_keeps_high_r4 : assert property (@(posedge clk) disable iff (!rstN)
    strobe.rise |=> $stable(highLen));

  p_fall_keeps_low_r3 : assert property (@(posedge clk) disable iff (!rstN)
    strobe.fall |=> $stable(lowLen));

  p_clear_zero_r7 : assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (lowLen == '0) && (highLen == '0) && (sinceEdge == '0));

endmodule

// File: rtl/pwm_capture.sv
module pwm_capture
  import pwm_cap_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [SEL_W-1:0]   srcSel,
  output logic [CNT_W-1:0]   lowLen,
  output logic [CNT_W-1:0]   highLen,
  output logic [CNT_W-1:0]   sinceEdge,
  output logic               capValid
);

  capStrobe_t strobe;

  pwm_cap_ctrl #(
    .NUM_SRC    (NUM_SRC),
    .SYNC_STAGES(SYNC_STAGES)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .srcIn   (srcIn),
    .srcSel  (srcSel),
    .strobe  (strobe),
    .capValid(capValid)
  );

  pwm_cap_datapath #(
    .CNT_W(CNT_W)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .lowLen   (lowLen),
    .highLen  (highLen),
    .sinceEdge(sinceEdge)
  );

endmodule

// File: tb/tb_pwm_capture.sv
module tb_pwm_capture;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_SRC    = 8;
  localparam int CNT_W      = 8;
  localparam int SEL_W      = 3;
  localparam int NVEC       = 6;
  // {high cycles, low cycles}; high >= 6 since the check wait is part of it
  localparam int VEC [NVEC][2] = '{'{7, 3}, '{10, 20}, '{40, 5},
                                  '{8, 100}, '{60, 60}, '{12, 1}};

  logic               clk = 1'b0;
  logic               rstN;
  logic [NUM_SRC-1:0] srcIn;
  logic [SEL_W-1:0]   srcSel;
  logic [CNT_W-1:0]   lowLen, highLen, sinceEdge;
  logic               capValid;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_capture #(.NUM_SRC(NUM_SRC), .CNT_W(CNT_W), .SYNC_STAGES(2)) dut (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .srcSel(srcSel),
    .lowLen(lowLen), .highLen(highLen), .sinceEdge(sinceEdge),
    .capValid(capValid)
  );

  task automatic chk(input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish();
    end
  end

  initial begin
    int s;
    rstN   = 1'b0;
    srcIn  = '0;
    srcSel = '0;
    waitCyc(3);
    // R9: reset state
    chk("R9", "lowLen", int'(lowLen), 0);
    chk("R9", "highLen", int'(highLen), 0);
    chk("R9", "sinceEdge", int'(sinceEdge), 0);
    chk("R9", "capValid", int'(capValid), 0);
    rstN = 1'b1;

    srcIn[0] = 1'b1;
    waitCyc(6);
    // Vector walk: R3, R4, R5, R8
    for (int i = 0; i < NVEC; i++) begin
      waitCyc(VEC[i][0] - 6);
      srcIn[0] = 1'b0;
      waitCyc(VEC[i][1]);
      srcIn[0] = 1'b1;
      waitCyc(6);
      chk("R4", "highLen", int'(highLen), VEC[i][0]);
      chk("R3", "lowLen", int'(lowLen), VEC[i][1]);
      chk("R5", "sinceEdge", int'(sinceEdge), 3);
      chk("R8", "capValid", int'(capValid), 1);
    end

    // R2: latency of two synchronizer flops plus latch
    srcIn[0] = 1'b0;
    waitCyc(2);
    chk("R2", "highLen before 3rd edge", int'(highLen), VEC[NVEC-1][0]);
    waitCyc(1);
    chk("R2", "highLen at 3rd edge", int'(highLen), 6);
    chk("R5", "sinceEdge at edge", int'(sinceEdge), 0);

    // R7: source change clears and blanks the switch transition
    srcIn[3] = 1'b1;
    srcSel   = 3'd3;
    waitCyc(1);
    chk("R7", "lowLen cleared", int'(lowLen), 0);
    chk("R7", "highLen cleared", int'(highLen), 0);
    chk("R7", "capValid dropped", int'(capValid), 0);
    chk("R7", "sinceEdge cleared", int'(sinceEdge), 0);
    // R1: activity on unselected sources is ignored
    for (int k = 0; k < 9; k++) begin
      srcIn[0] = ~srcIn[0];
      srcIn[5] = ~srcIn[5];
      waitCyc(1);
    end
    chk("R1", "lowLen with other sources toggling", int'(lowLen), 0);
    chk("R1", "highLen with other sources toggling", int'(highLen), 0);
    chk("R7", "sinceEdge after blanking", int'(sinceEdge), 6);

    // R8: a single phase does not make the result valid
    s = int'(sinceEdge);
    srcIn[3] = 1'b0;
    waitCyc(3);
    chk("R4", "highLen first phase on new source", int'(highLen), s + 3);
    chk("R8", "capValid after one phase", int'(capValid), 0);
    waitCyc(2);
    srcIn[3] = 1'b1;
    waitCyc(3);
    chk("R3", "lowLen on new source", int'(lowLen), 5);
    chk("R8", "capValid after both phases", int'(capValid), 1);

    // R6: saturation
    waitCyc(300);
    chk("R6", "sinceEdge saturated", int'(sinceEdge), 255);
    srcIn[3] = 1'b0;
    waitCyc(3);
    chk("R6", "highLen saturated", int'(highLen), 255);
    chk("R6", "lowLen unchanged", int'(lowLen), 5);

    finished = 1'b1;
    finish();
  end

endmodule